// File: doc/BRIEF.md
# Receive Holding Buffer with Break Insertion

This block sits between a serial deserializer and a register interface. It stores up to four received bytes and hands them to the bus in arrival order. It raises a ready flag while it holds data and a full flag when all four slots are occupied. It also tells the upstream receiver whether another byte may be delivered.

A break event writes a zero byte into the buffer and sets a sticky break-change flag. If the buffer is already full, the zero byte replaces the newest entry, so a break is never lost. A receiver-reset command empties the buffer in one cycle. The read port always shows the oldest byte, and shows zero when nothing is held. A read strobe consumes that byte at the clock edge.

Control is a three-state machine:
- RXB_EMPTY holds no data.
- RXB_PARTIAL holds between one and DEPTH-1 bytes.
- RXB_FULL holds DEPTH bytes.

Its transitions are:
- fill (EMPTY to PARTIAL): a write with nothing held.
- top-up (PARTIAL to FULL): a write without a pop at DEPTH-1 bytes.
- drain (PARTIAL to EMPTY): a pop without a write at one byte.
- release (FULL to PARTIAL): a pop without a write.
- flush (any state to EMPTY): a receiver reset.

A break overwrite keeps FULL unchanged.

Top module: `rxb_buffer`

## Requirements
- R1: Bytes leave the buffer in the order they were stored; `rd_data` shows the oldest held byte, and asserting `rd_req` removes it at the clock edge.
- R2: `can_accept` is high exactly when `rx_en` is high and `full` is low; a byte offered on `push_valid` while `can_accept` is low is discarded.
- R3: A cycle with `brk_evt` high stores the value 0x00 and sets `brk_flag` (if `push_valid` is high in that cycle, its byte is discarded). `brk_clr` clears `brk_flag`, but a break in the same cycle wins.
- R4: A break while the buffer holds four bytes and no read occurs replaces the newest entry with 0x00. It leaves the three older entries and the count unchanged.
- R5: Every stored byte leaves `rdy` high after the edge; `full` rises when the count reaches four.
- R6: A read that removes a byte, with no break in the same cycle, leaves `full` low; `rdy` falls when the count reaches zero.
- R7: `rd_req` while the buffer is empty leaves `rd_data` at 0x00 and changes no state.
- R8: `flush` empties the buffer and clears `rdy` and `full` in one cycle, overriding any write or read in that cycle; `brk_flag` is not affected by it.
- R9: A write and a read in the same cycle are both performed and leave the count unchanged.
- R10: After reset the buffer is empty: `rdy`, `full` and `brk_flag` are low and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enabled |
| push_valid | input | 1 | Received byte offered |
| push_data | input | WIDTH | Received byte |
| brk_evt | input | 1 | Break detected; stores 0x00 |
| brk_clr | input | 1 | Clear the break-change flag |
| flush | input | 1 | Receiver-reset command |
| rd_req | input | 1 | Consume the oldest byte |
| rd_data | output | WIDTH | Oldest byte, 0 when empty |
| rdy | output | 1 | At least one byte held |
| full | output | 1 | All slots held |
| can_accept | output | 1 | Upstream may deliver a byte |
| brk_flag | output | 1 | Sticky break-change flag |

## Verification
The hardest case to reach is a break that arrives while the buffer is full. Its outcome also depends on whether a read happens in the same edge: without a read, the newest entry is overwritten; with a read, a normal write is paired with a pop. Normal traffic rarely reaches this case, because `can_accept` stops data once the buffer is full. The bench therefore fills the buffer by direct sequences and then issues breaks with and without reads. Random cycles are weighted toward breaks and few reads, so the full state recurs often.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    typedef enum logic [1:0] {
        RXB_EMPTY   = 2'd0,
        RXB_PARTIAL = 2'd1,
        RXB_FULL    = 2'd2
    } rxb_state_e;
endpackage

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
    import rxb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic push_valid,
    input  logic brk_evt,
    input  logic rd_req,
    input  logic flush,
    output logic do_write,
    output logic do_over,
    output logic do_pop,
    output logic can_accept,
    output logic rdy,
    output logic full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    rxb_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             data_ok, any_push, is_full;

    always_comb begin
        is_full    = (state_q == RXB_FULL);
        can_accept = rx_en && !is_full;
        do_pop     = rd_req && (state_q != RXB_EMPTY) && !flush;
        data_ok    = push_valid && can_accept && !brk_evt;
        any_push   = (data_ok || brk_evt) && !flush;
        do_over    = any_push && is_full && !do_pop;
        do_write   = any_push && !do_over;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (flush) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(do_write) - CNT_W'(do_pop);
        end
        unique case (state_q)
            RXB_EMPTY: begin
                if (!flush && do_write)
                    state_d = (DEPTH == 1) ? RXB_FULL : RXB_PARTIAL;
            end
            RXB_PARTIAL: begin
                if (flush)
                    state_d = RXB_EMPTY;
                else if (do_write && !do_pop && cnt_q == CNT_W'(DEPTH - 1))
                    state_d = RXB_FULL;
                else if (do_pop && !do_write && cnt_q == CNT_W'(1))
                    state_d = RXB_EMPTY;
            end
            RXB_FULL: begin
                if (flush)
                    state_d = RXB_EMPTY;
                else if (do_pop && !do_write)
                    state_d = (DEPTH == 1) ? RXB_EMPTY : RXB_PARTIAL;
            end
            default: state_d = RXB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RXB_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        rdy  = (state_q != RXB_EMPTY);
        full = (state_q == RXB_FULL);
    end
endmodule

// File: rtl/rxb_store.sv
module rxb_store #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_write,
    input  logic             do_over,
    input  logic             do_pop,
    input  logic             flush,
    input  logic             nonempty,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wr_ptr, rd_ptr, newest;
    logic [WIDTH-1:0] slot [DEPTH];

    assign newest = (wr_ptr == '0) ? LAST : wr_ptr - PTR_W'(1);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic we;
        assign we = (do_write && wr_ptr == PTR_W'(i)) ||
                    (do_over  && newest == PTR_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  slot[i] <= '0;
            else if (we) slot[i] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_write) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop)   rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
        end
    end

    assign rdata = nonempty ? slot[rd_ptr] : '0;
endmodule

// File: rtl/rxb_buffer.sv
module rxb_buffer #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_data,
    input  logic             brk_evt,
    input  logic             brk_clr,
    input  logic             flush,
    input  logic             rd_req,
    output logic [WIDTH-1:0] rd_data,
    output logic             rdy,
    output logic             full,
    output logic             can_accept,
    output logic             brk_flag
);
    logic             do_write, do_over, do_pop;
    logic [WIDTH-1:0] wdata;

    assign wdata = brk_evt ? '0 : push_data;

    rxb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .push_valid (push_valid),
        .brk_evt    (brk_evt),
        .rd_req     (rd_req),
        .flush      (flush),
        .do_write   (do_write),
        .do_over    (do_over),
        .do_pop     (do_pop),
        .can_accept (can_accept),
        .rdy        (rdy),
        .full       (full)
    );

    rxb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_write (do_write),
        .do_over  (do_over),
        .do_pop   (do_pop),
        .flush    (flush),
        .nonempty (rdy),
        .wdata    (wdata),
        .rdata    (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       brk_flag <= 1'b0;
        else if (brk_evt) brk_flag <= 1'b1;
        else if (brk_clr) brk_flag <= 1'b0;
    end
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             push_valid,
    input logic [WIDTH-1:0] push_data,
    input logic             brk_evt,
    input logic             brk_clr,
    input logic             flush,
    input logic             rd_req,
    input logic [WIDTH-1:0] rd_data,
    input logic             rdy,
    input logic             full,
    input logic             can_accept,
    input logic             brk_flag
);
    a_r2_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !can_accept);

    a_r3_break_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> brk_flag);

    a_r5_push_makes_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((brk_evt || (push_valid && can_accept)) && !flush) |=> rdy);

    a_r5_full_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> rdy);

    a_r6_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rdy && !brk_evt && !flush) |=> !full);

    a_r7_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (rd_data == '0));

    a_r7_empty_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && rd_req && !push_valid && !brk_evt && !flush) |=> !rdy);

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!rdy && !full));

    a_r8_flush_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !brk_evt && !brk_clr) |=> $stable(brk_flag));
endmodule

bind rxb_buffer rxb_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_rxb_buffer.sv
`timescale 1ns/1ps
module tb_rxb_buffer;
    localparam int DEPTH = 4;
    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_en = 1'b0, push_valid = 1'b0, brk_evt = 1'b0;
    logic             brk_clr = 1'b0, flush = 1'b0, rd_req = 1'b0;
    logic [WIDTH-1:0] push_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic             rdy, full, can_accept, brk_flag;

    int n_tests = 0;
    int n_fail  = 0;

    logic [WIDTH-1:0] mq [DEPTH];
    int               mcnt = 0;
    logic             mflag = 1'b0;

    always #2 clk = ~clk;

    rxb_buffer #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .push_valid(push_valid),
        .push_data(push_data), .brk_evt(brk_evt), .brk_clr(brk_clr),
        .flush(flush), .rd_req(rd_req), .rd_data(rd_data), .rdy(rdy),
        .full(full), .can_accept(can_accept), .brk_flag(brk_flag)
    );

    function automatic logic [WIDTH-1:0] exp_head();
        return (mcnt > 0) ? mq[0] : '0;
    endfunction

    function automatic logic exp_accept(input logic en);
        return en && (mcnt < DEPTH);
    endfunction

    task automatic chk(input string tag, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk(mcnt > 0 ? "R1 rd_data" : "R7 rd_data", rd_data, exp_head());
        chk("R5/R6 rdy", WIDTH'(rdy), WIDTH'(mcnt > 0));
        chk("R5/R6 full", WIDTH'(full), WIDTH'(mcnt == DEPTH));
        chk("R2 can_accept", WIDTH'(can_accept), WIDTH'(exp_accept(rx_en)));
        chk("R3 brk_flag", WIDTH'(brk_flag), WIDTH'(mflag));
    endtask

    task automatic model_edge();
        logic             pop, dpush, push;
        logic [WIDTH-1:0] val;
        if (brk_evt)      mflag = 1'b1;
        else if (brk_clr) mflag = 1'b0;
        if (flush) begin
            mcnt = 0;
            return;
        end
        pop   = rd_req && mcnt > 0;
        dpush = push_valid && exp_accept(rx_en) && !brk_evt;
        push  = dpush || brk_evt;
        val   = brk_evt ? '0 : push_data;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
            mcnt--;
        end
        if (push) begin
            if (mcnt == DEPTH) mq[DEPTH-1] = val;
            else begin
                mq[mcnt] = val;
                mcnt++;
            end
        end
    endtask

    task automatic step(input logic en, input logic pv, input logic [WIDTH-1:0] pd,
                        input logic brk, input logic clr, input logic fl,
                        input logic rd);
        @(negedge clk);
        rx_en = en; push_valid = pv; push_data = pd; brk_evt = brk;
        brk_clr = clr; flush = fl; rd_req = rd;
        #1;
        check_outputs();
        model_edge();
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 rdy", WIDTH'(rdy), 0);
        chk("R10 full", WIDTH'(full), 0);
        chk("R10 brk_flag", WIDTH'(brk_flag), 0);
        chk("R10 rd_data", rd_data, 0);
        rst_n = 1'b1;

        // R7: reads while empty
        step(1, 0, 8'h00, 0, 0, 0, 1);
        step(1, 0, 8'h00, 0, 0, 0, 1);
        // R2: disabled receiver drops bytes
        step(0, 1, 8'h55, 0, 0, 0, 0);
        step(0, 0, 8'h00, 0, 0, 0, 0);
        // R1/R5: fill in order
        step(1, 1, 8'hA1, 0, 0, 0, 0);
        step(1, 1, 8'hA2, 0, 0, 0, 0);
        step(1, 1, 8'hA3, 0, 0, 0, 0);
        step(1, 1, 8'hA4, 0, 0, 0, 0);
        // R2: offered byte while full is dropped
        step(1, 1, 8'hEE, 0, 0, 0, 0);
        // R4: break while full overwrites newest
        step(1, 0, 8'h00, 1, 0, 0, 0);
        // R3: clear the flag, then break and clear together
        step(1, 0, 8'h00, 0, 1, 0, 0);
        // R9 with break while full and a read: write plus pop
        step(1, 0, 8'h00, 1, 1, 0, 1);
        // R6: drain
        step(1, 0, 8'h00, 0, 0, 0, 1);
        step(1, 0, 8'h00, 0, 0, 0, 1);
        // R9: data write and read together
        step(1, 1, 8'h3C, 0, 0, 0, 1);
        step(1, 0, 8'h00, 0, 0, 0, 1);
        step(1, 0, 8'h00, 0, 0, 0, 1);
        step(1, 0, 8'h00, 0, 0, 0, 0);
        // R8: flush overrides a write and a read; flag untouched
        step(1, 1, 8'h11, 0, 0, 0, 0);
        step(1, 1, 8'h22, 0, 0, 1, 1);
        step(1, 0, 8'h00, 0, 0, 0, 0);

        void'($urandom(32'h5EED));
        for (int c = 0; c < 4000; c++) begin
            logic en, pv, brk, clr, fl, rd;
            en  = ($urandom % 8) != 0;
            pv  = ($urandom % 3) != 0;
            brk = ($urandom % 7) == 0;
            clr = ($urandom % 9) == 0;
            fl  = ($urandom % 40) == 0;
            rd  = ($urandom % 4) == 0;
            step(en, pv, WIDTH'($urandom), brk, clr, fl, rd);
        end
        @(negedge clk);
        #1;
        check_outputs();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule